// File: doc/BRIEF.md
# Two-Slot Issue Pairing and Register Hazard Controller

This controller sits between a two-wide decode queue and two execution pipes. Every cycle it looks at the two oldest decoded instructions: slot A, the older one, and slot B, the one behind it. It decides whether slot A goes to pipe 0. It also decides whether slot B may go to pipe 1 in the same cycle. Pipe 0 can execute every instruction class. Pipe 1 is narrower, and only a fixed set of class combinations may leave together.

To keep the pipes in order, the controller keeps a small scoreboard. For every architectural register it holds a countdown of how many cycles remain before an in-flight result reaches its forwarding point. It also remembers which register an outstanding divide will write, and it flags when the previous cycle issued a load.

From this state it works out three things for each slot: whether the slot must stall, whether its operands come from the early execute-stage bypass, and how many queue entries to pop.

Top module: `pair_issue_ctl`

## Requirements
- R1: Class flags are one-hot, with bit 0 alu, bit 1 lsu, bit 2 branch, bit 3 mul, bit 4 div and bit 5 csr. A valid slot A with no hazard, no stall and no hold issues whatever its class.
- R2: Slot B issues only if its class is alu, lsu, branch or mul. A div or csr slot B is never issued.
- R3: Slot B pairs only in three cases: A is alu, lsu or mul and B is alu or branch; A is alu or mul and B is lsu; A is alu or lsu and B is mul. Any other combination leaves B unissued.
- R4: While irq_i is high, slot B is not issued. Slot A issues as usual.
- R5: issue_b_o is never high unless issue_a_o is high in the same cycle.
- R6: Slot B is not paired when slot A writes a nonzero register that B reads or also writes.
- R7: After an instruction writing register r (r≠0) issues, any later instruction that reads or writes r waits a number of cycles. The wait is 0 for alu and branch, LAT_LSU-1 for lsu, MUL_STAGES-1 for mul and LAT_CSR-1 for csr. Register 0 never causes a wait.
- R8: In the cycle directly after a load issues, a mul, div or csr instruction is held in either slot. A load is an lsu instruction with a nonzero destination.
- R9: A slot's fwd bit (bit 0 for rs1, bit 1 for rs2) is high when that source is the nonzero destination of an alu instruction issued in the previous cycle.
- R10: Once a divide issues, its destination stays busy and no second divide issues, until the cycle after div_done_i is seen high.
- R11: While stall_i is high, neither slot issues.
- R12: While rst_i is high, no slot issues. After reset the scoreboard is empty.
- R13: adv_o equals the number of slots issued in the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| a_vld_i | input | 1 | Slot A holds an instruction |
| a_cls_i | input | 6 | Slot A class, one-hot |
| a_rd_i | input | RW | Slot A destination |
| a_rs1_i | input | RW | Slot A first source |
| a_rs2_i | input | RW | Slot A second source |
| b_vld_i | input | 1 | Slot B holds an instruction |
| b_cls_i | input | 6 | Slot B class, one-hot |
| b_rd_i | input | RW | Slot B destination |
| b_rs1_i | input | RW | Slot B first source |
| b_rs2_i | input | RW | Slot B second source |
| irq_i | input | 1 | Interrupt pending |
| stall_i | input | 1 | Downstream stall |
| div_done_i | input | 1 | Divider finished |
| issue_a_o | output | 1 | Slot A issues to pipe 0 |
| issue_b_o | output | 1 | Slot B issues to pipe 1 |
| adv_o | output | 2 | Queue entries consumed |
| fwd_a_o | output | 2 | Slot A bypass select per source |
| fwd_b_o | output | 2 | Slot B bypass select per source |

## Verification
The bench sweeps all 36 class pairs with and without a pending interrupt. A pairing table with one wrong entry would let a divide into pipe 1, or would waste a legal dual slot.

The bench then walks a dependent instruction through each producer's wait window. A countdown that is one cycle short lets a consumer read a stale value, and one that is one cycle long shows up as an extra bubble.

Separate cases cover the load shadow, the divide busy window and its release on the done pulse, and the register clashes between A and B. A design that gets any of these wrong either issues out of order or deadlocks the queue.

A long randomized run over four registers mixes all of these events against an independent cycle model.

// File: rtl/pair_issue_pkg.sv
package pair_issue_pkg;
  localparam int NCLS   = 6;
  localparam int CL_ALU = 0;
  localparam int CL_LSU = 1;
  localparam int CL_BRA = 2;
  localparam int CL_MUL = 3;
  localparam int CL_DIV = 4;
  localparam int CL_CSR = 5;
  localparam int NQ     = 6;  // scoreboard lookups: A rs1,rs2,rd then B rs1,rs2,rd

  typedef logic [NCLS-1:0] cls_t;

  // classes pipe 1 can execute
  function automatic logic pipe1_ok(cls_t c);
    return c[CL_ALU] | c[CL_LSU] | c[CL_BRA] | c[CL_MUL];
  endfunction

  // legal (A, B) class combinations for a dual issue
  function automatic logic class_pair_ok(cls_t a, cls_t b);
    logic r;
    r = ((a[CL_ALU] | a[CL_LSU] | a[CL_MUL]) & (b[CL_ALU] | b[CL_BRA]))
      | ((a[CL_ALU] | a[CL_MUL]) & b[CL_LSU])
      | ((a[CL_ALU] | a[CL_LSU]) & b[CL_MUL]);
    return r;
  endfunction

  // classes that may not follow a load directly
  function automatic logic load_shadow(cls_t c);
    return c[CL_MUL] | c[CL_DIV] | c[CL_CSR];
  endfunction

  // cycles a consumer waits behind a producer of this class
  function automatic int unsigned wait_cycles(cls_t c, int unsigned lat_lsu,
                                              int unsigned lat_mul, int unsigned lat_csr);
    if (c[CL_LSU]) return lat_lsu - 1;
    if (c[CL_MUL]) return lat_mul - 1;
    if (c[CL_CSR]) return lat_csr - 1;
    return 0;
  endfunction
endpackage

// File: rtl/issue_pair_rules.sv
module issue_pair_rules
  import pair_issue_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic [NCLS-1:0] a_cls_i,
  input  logic [NCLS-1:0] b_cls_i,
  input  logic [RW-1:0]   a_rd_i,
  input  logic [RW-1:0]   b_rd_i,
  input  logic [RW-1:0]   b_rs1_i,
  input  logic [RW-1:0]   b_rs2_i,
  output logic            ok_o
);
  logic class_ok_w;
  logic a_writes_w;
  logic clash_w;

  assign class_ok_w = pipe1_ok(b_cls_i) & class_pair_ok(a_cls_i, b_cls_i);
  assign a_writes_w = (a_rd_i != '0);
  assign clash_w    = a_writes_w & ((b_rs1_i == a_rd_i) | (b_rs2_i == a_rd_i) |
                                    (b_rd_i == a_rd_i));
  assign ok_o       = class_ok_w & ~clash_w;
endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
  import pair_issue_pkg::*;
#(
  parameter  int NREG    = 32,
  parameter  int LAT_LSU = 2,
  parameter  int LAT_MUL = 3,
  parameter  int LAT_CSR = 2,
  localparam int RW      = $clog2(NREG),
  localparam int LMAX    = (LAT_LSU > LAT_MUL) ? ((LAT_LSU > LAT_CSR) ? LAT_LSU : LAT_CSR)
                                               : ((LAT_MUL > LAT_CSR) ? LAT_MUL : LAT_CSR),
  localparam int CW      = (LMAX > 2) ? $clog2(LMAX) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_i,
  input  logic                   wa_en_i,
  input  logic [RW-1:0]          wa_idx_i,
  input  logic [NCLS-1:0]        wa_cls_i,
  input  logic                   wb_en_i,
  input  logic [RW-1:0]          wb_idx_i,
  input  logic [NCLS-1:0]        wb_cls_i,
  input  logic                   div_done_i,
  input  logic [NQ-1:0][RW-1:0]  q_idx_i,
  output logic [NQ-1:0]          q_busy_o,
  output logic [NQ-1:0]          q_fresh_o,
  output logic                   div_busy_o
);
  logic [CW-1:0] cnt [NREG];
  logic          div_busy;
  logic [RW-1:0] div_rd;
  logic [1:0]    la_v;
  logic [RW-1:0] la_rd [2];

  logic          div_start_w;
  logic          wa_set_w;
  logic          wb_set_w;
  logic [CW-1:0] hold_a_w;
  logic [CW-1:0] hold_b_w;

  assign div_start_w = wa_en_i & wa_cls_i[CL_DIV];
  assign wa_set_w    = wa_en_i & ~wa_cls_i[CL_DIV] & (wa_idx_i != '0);
  assign wb_set_w    = wb_en_i & ~wb_cls_i[CL_DIV] & (wb_idx_i != '0);
  assign hold_a_w    = CW'(wait_cycles(wa_cls_i, LAT_LSU, LAT_MUL, LAT_CSR));
  assign hold_b_w    = CW'(wait_cycles(wb_cls_i, LAT_LSU, LAT_MUL, LAT_CSR));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int r = 0; r < NREG; r++) cnt[r] <= '0;
    end else begin
      for (int r = 1; r < NREG; r++) begin
        if (wa_set_w && wa_idx_i == RW'(r))      cnt[r] <= hold_a_w;
        else if (wb_set_w && wb_idx_i == RW'(r)) cnt[r] <= hold_b_w;
        else if (cnt[r] != '0)                   cnt[r] <= cnt[r] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      div_busy <= 1'b0;
      div_rd   <= '0;
      la_v     <= '0;
      la_rd[0] <= '0;
      la_rd[1] <= '0;
    end else begin
      if (div_start_w) begin
        div_busy <= 1'b1;
        div_rd   <= wa_idx_i;
      end else if (div_done_i) begin
        div_busy <= 1'b0;
      end
      la_v[0]  <= wa_set_w & wa_cls_i[CL_ALU];
      la_v[1]  <= wb_set_w & wb_cls_i[CL_ALU];
      la_rd[0] <= wa_idx_i;
      la_rd[1] <= wb_idx_i;
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_query
    logic nz_w;
    assign nz_w         = (q_idx_i[q] != '0);
    assign q_busy_o[q]  = nz_w & ((cnt[q_idx_i[q]] != '0) | (div_busy & (div_rd == q_idx_i[q])));
    assign q_fresh_o[q] = nz_w & ((la_v[0] & (la_rd[0] == q_idx_i[q])) |
                                  (la_v[1] & (la_rd[1] == q_idx_i[q])));
  end

  assign div_busy_o = div_busy;

  AST_DIV_ONE_AT_A_TIME: assert property (@(posedge clk_i) disable iff (rst_i)
    div_start_w |-> !div_busy); // R10
  AST_DIV_RELEASE: assert property (@(posedge clk_i) disable iff (rst_i)
    (div_busy && div_done_i) |=> !div_busy); // R10
endmodule

// File: rtl/pair_issue_ctl.sv
module pair_issue_ctl
  import pair_issue_pkg::*;
#(
  parameter  int NREG       = 32,
  parameter  bit DUAL_EN    = 1'b1,
  parameter  int MUL_STAGES = 3,
  parameter  int LAT_LSU    = 2,
  parameter  int LAT_CSR    = 2,
  localparam int RW         = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          a_vld_i,
  input  logic [5:0]    a_cls_i,
  input  logic [RW-1:0] a_rd_i,
  input  logic [RW-1:0] a_rs1_i,
  input  logic [RW-1:0] a_rs2_i,
  input  logic          b_vld_i,
  input  logic [5:0]    b_cls_i,
  input  logic [RW-1:0] b_rd_i,
  input  logic [RW-1:0] b_rs1_i,
  input  logic [RW-1:0] b_rs2_i,
  input  logic          irq_i,
  input  logic          stall_i,
  input  logic          div_done_i,
  output logic          issue_a_o,
  output logic          issue_b_o,
  output logic [1:0]    adv_o,
  output logic [1:0]    fwd_a_o,
  output logic [1:0]    fwd_b_o
);
  logic [NQ-1:0][RW-1:0] q_idx_w;
  logic [NQ-1:0]         q_busy_w;
  logic [NQ-1:0]         q_fresh_w;
  logic                  div_busy_w;
  logic                  pair_ok_w;
  logic                  last_load;

  logic a_haz_w, b_haz_w, a_shadow_w, b_shadow_w, a_div_w, dual_gate_w;
  logic a_load_w, b_load_w;

  assign q_idx_w = {b_rd_i, b_rs2_i, b_rs1_i, a_rd_i, a_rs2_i, a_rs1_i};

  issue_scoreboard #(
    .NREG(NREG), .LAT_LSU(LAT_LSU), .LAT_MUL(MUL_STAGES), .LAT_CSR(LAT_CSR)
  ) u_sb (
    .clk_i(clk_i), .rst_i(rst_i),
    .wa_en_i(issue_a_o), .wa_idx_i(a_rd_i), .wa_cls_i(a_cls_i),
    .wb_en_i(issue_b_o), .wb_idx_i(b_rd_i), .wb_cls_i(b_cls_i),
    .div_done_i(div_done_i),
    .q_idx_i(q_idx_w), .q_busy_o(q_busy_w), .q_fresh_o(q_fresh_w),
    .div_busy_o(div_busy_w)
  );

  issue_pair_rules #(.RW(RW)) u_pair (
    .a_cls_i(a_cls_i), .b_cls_i(b_cls_i), .a_rd_i(a_rd_i),
    .b_rd_i(b_rd_i), .b_rs1_i(b_rs1_i), .b_rs2_i(b_rs2_i), .ok_o(pair_ok_w)
  );

  assign a_haz_w     = |q_busy_w[2:0];
  assign b_haz_w     = |q_busy_w[5:3];
  assign a_shadow_w  = last_load & load_shadow(a_cls_i);
  assign b_shadow_w  = last_load & load_shadow(b_cls_i);
  assign a_div_w     = a_cls_i[CL_DIV] & div_busy_w;
  assign dual_gate_w = DUAL_EN & b_vld_i & ~irq_i;

  assign issue_a_o = ~rst_i & a_vld_i & ~stall_i & ~a_haz_w & ~a_div_w & ~a_shadow_w;
  assign issue_b_o = issue_a_o & dual_gate_w & pair_ok_w & ~b_haz_w & ~b_shadow_w;
  assign adv_o     = {1'b0, issue_a_o} + {1'b0, issue_b_o};
  assign fwd_a_o   = q_fresh_w[1:0];
  assign fwd_b_o   = q_fresh_w[4:3];

  assign a_load_w = issue_a_o & a_cls_i[CL_LSU] & (a_rd_i != '0);
  assign b_load_w = issue_b_o & b_cls_i[CL_LSU] & (b_rd_i != '0);

  always_ff @(posedge clk_i) begin
    if (rst_i) last_load <= 1'b0;
    else       last_load <= a_load_w | b_load_w;
  end

  AST_B_NEEDS_A: assert property (@(posedge clk_i) disable iff (rst_i)
    issue_b_o |-> issue_a_o); // R5
  AST_IRQ_NO_PAIR: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_i |-> !issue_b_o); // R4
  AST_PIPE1_CLASS: assert property (@(posedge clk_i) disable iff (rst_i)
    issue_b_o |-> (b_cls_i[CL_DIV] == 1'b0 && b_cls_i[CL_CSR] == 1'b0)); // R2
  AST_LOAD_SHADOW: assert property (@(posedge clk_i) disable iff (rst_i)
    a_load_w |=> !(issue_a_o && (a_cls_i[CL_MUL] || a_cls_i[CL_DIV] || a_cls_i[CL_CSR]))); // R8
  AST_STALL_BLOCKS: assert property (@(posedge clk_i) disable iff (rst_i)
    stall_i |-> (!issue_a_o && !issue_b_o)); // R11
  AST_B_DISTINCT_RD: assert property (@(posedge clk_i) disable iff (rst_i)
    (issue_b_o && a_rd_i != '0) |-> (b_rd_i != a_rd_i)); // R6
endmodule

// File: tb/pair_issue_ctl_tb.sv
`timescale 1ns/1ps
module pair_issue_ctl_tb;
  localparam int NREG = 32;
  localparam int RW   = 5;
  localparam int LSU  = 2;
  localparam int MULS = 3;
  localparam int CSR  = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst;
  logic av, bv, irq, stall, done;
  logic [5:0] acls, bcls;
  logic [RW-1:0] ard, ars1, ars2, brd, brs1, brs2;
  logic issue_a, issue_b;
  logic [1:0] adv, fwa, fwb;

  pair_issue_ctl u_dut (
    .clk_i(clk), .rst_i(rst),
    .a_vld_i(av), .a_cls_i(acls), .a_rd_i(ard), .a_rs1_i(ars1), .a_rs2_i(ars2),
    .b_vld_i(bv), .b_cls_i(bcls), .b_rd_i(brd), .b_rs1_i(brs1), .b_rs2_i(brs2),
    .irq_i(irq), .stall_i(stall), .div_done_i(done),
    .issue_a_o(issue_a), .issue_b_o(issue_b), .adv_o(adv),
    .fwd_a_o(fwa), .fwd_b_o(fwb)
  );

  // staged stimulus, applied at the falling edge
  int s_rst, s_av, s_bv, s_irq, s_stall, s_done;
  int s_ac, s_ard, s_ar1, s_ar2, s_bc, s_brd, s_br1, s_br2;

  // reference model state
  int cnt [NREG];
  bit dbusy;
  int drd;
  bit lload;
  bit lv [2];
  int lrd [2];

  int nchk = 0, nfail = 0;
  bit ended = 0;

  function automatic bit mbusy(int i);
    return i != 0 && (cnt[i] > 0 || (dbusy && drd == i));
  endfunction
  function automatic bit mfresh(int i);
    return i != 0 && ((lv[0] && lrd[0] == i) || (lv[1] && lrd[1] == i));
  endfunction
  function automatic int wait_of(int c);
    case (c)
      1: return LSU - 1;
      3: return MULS - 1;
      5: return CSR - 1;
      default: return 0;
    endcase
  endfunction
  function automatic bit pair_tab(int ca, int cb);
    case (cb)
      0, 2: return ca == 0 || ca == 1 || ca == 3;
      1:    return ca == 0 || ca == 3;
      3:    return ca == 0 || ca == 1;
      default: return 0;
    endcase
  endfunction
  function automatic bit shadow(int c);
    return c == 3 || c == 4 || c == 5;
  endfunction

  task automatic check(string tag, string what, int got, int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, got, exp, $time);
    end
  endtask

  task automatic step(string tag);
    bit ea, eb;
    int efa, efb;
    @(negedge clk);
    rst = s_rst[0]; av = s_av[0]; bv = s_bv[0]; irq = s_irq[0]; stall = s_stall[0];
    done = s_done[0];
    acls = 6'(1 << s_ac); ard = RW'(s_ard); ars1 = RW'(s_ar1); ars2 = RW'(s_ar2);
    bcls = 6'(1 << s_bc); brd = RW'(s_brd); brs1 = RW'(s_br1); brs2 = RW'(s_br2);
    #1;
    ea = s_rst == 0 && s_av != 0 && s_stall == 0 &&
         !(mbusy(s_ar1) || mbusy(s_ar2) || mbusy(s_ard)) &&
         !(s_ac == 4 && dbusy) && !(lload && shadow(s_ac));
    eb = ea && s_bv != 0 && s_irq == 0 && pair_tab(s_ac, s_bc) &&
         !(s_ard != 0 && (s_br1 == s_ard || s_br2 == s_ard || s_brd == s_ard)) &&
         !(mbusy(s_br1) || mbusy(s_br2) || mbusy(s_brd)) && !(lload && shadow(s_bc));
    efa = {30'd0, mfresh(s_ar2), mfresh(s_ar1)};
    efb = {30'd0, mfresh(s_br2), mfresh(s_br1)};
    check(tag, "issue_a", int'(issue_a), int'(ea));
    check(tag, "issue_b", int'(issue_b), int'(eb));
    check("R13", "adv", int'(adv), int'(ea) + int'(eb));
    check(tag, "fwd_a", int'(fwa), efa);
    check(tag, "fwd_b", int'(fwb), efb);
    if (s_rst != 0) begin
      foreach (cnt[r]) cnt[r] = 0;
      dbusy = 0; drd = 0; lload = 0; lv[0] = 0; lv[1] = 0; lrd[0] = 0; lrd[1] = 0;
    end else begin
      foreach (cnt[r]) if (cnt[r] > 0) cnt[r]--;
      if (ea && s_ac == 4) begin dbusy = 1; drd = s_ard; end
      else if (s_done != 0) dbusy = 0;
      if (ea && s_ac != 4 && s_ard != 0) cnt[s_ard] = wait_of(s_ac);
      if (eb && s_brd != 0) cnt[s_brd] = wait_of(s_bc);
      lload = (ea && s_ac == 1 && s_ard != 0) || (eb && s_bc == 1 && s_brd != 0);
      lv[0] = ea && s_ac == 0 && s_ard != 0; lrd[0] = s_ard;
      lv[1] = eb && s_bc == 0 && s_brd != 0; lrd[1] = s_brd;
    end
  endtask

  task automatic clr();
    s_rst = 0; s_av = 0; s_bv = 0; s_irq = 0; s_stall = 0; s_done = 0;
  endtask
  task automatic seta(int c, int rd, int r1, int r2);
    s_av = 1; s_ac = c; s_ard = rd; s_ar1 = r1; s_ar2 = r2;
  endtask
  task automatic setb(int c, int rd, int r1, int r2);
    s_bv = 1; s_bc = c; s_brd = rd; s_br1 = r1; s_br2 = r2;
  endtask
  task automatic idle(int n);
    clr(); s_done = 1;
    repeat (n) step("R10");
    s_done = 0;
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    nfail++;
    $display("FAIL R12 watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    rst = 1; av = 0; bv = 0; irq = 0; stall = 0; done = 0;
    acls = '0; bcls = '0; ard = '0; ars1 = '0; ars2 = '0; brd = '0; brs1 = '0; brs2 = '0;
    foreach (cnt[r]) cnt[r] = 0;
    dbusy = 0; drd = 0; lload = 0; lv[0] = 0; lv[1] = 0; lrd[0] = 0; lrd[1] = 0;
    clr(); s_ac = 0; s_bc = 0; s_ard = 0; s_ar1 = 0; s_ar2 = 0; s_brd = 0; s_br1 = 0; s_br2 = 0;

    // R12: nothing issues under reset
    s_rst = 1; seta(0, 1, 2, 3); setb(0, 4, 5, 6);
    repeat (3) step("R12");
    clr(); step("R12");

    // R1: every class alone in slot A
    for (int c = 0; c < 6; c++) begin
      clr(); seta(c, 1, 2, 3); step("R1"); idle(4);
    end

    // R2 R3 R4: all class pairs, interrupt off and on
    for (int ia = 0; ia < 2; ia++)
      for (int ca = 0; ca < 6; ca++)
        for (int cb = 0; cb < 6; cb++) begin
          clr(); seta(ca, 1, 2, 3); setb(cb, 4, 5, 6); s_irq = ia;
          step(ia != 0 ? "R4" : (cb == 4 || cb == 5) ? "R2" : "R3");
          idle(4);
        end

    // R5: slot B alone never issues
    clr(); setb(0, 4, 5, 6); step("R5"); idle(1);

    // R6: B reads or rewrites A's destination
    clr(); seta(0, 15, 1, 2); setb(0, 16, 15, 3); step("R6"); idle(2);
    clr(); seta(0, 15, 1, 2); setb(0, 15, 3, 4); step("R6"); idle(2);
    clr(); seta(0, 0, 1, 2);  setb(0, 5, 0, 3);  step("R6"); idle(2);

    // R7: dependent waits behind each producer class
    for (int p = 0; p < 6; p++) begin
      if (p == 4) continue;
      clr(); seta(p, 9, 1, 2); step("R7");
      clr(); seta(0, 20, 9, 3);
      repeat (4) step("R7");
      idle(3);
      clr(); seta(p, 9, 1, 2); step("R7");
      clr(); seta(0, 9, 3, 4);  // rewrite of the same register
      repeat (3) step("R7");
      idle(3);
    end

    // R8: load shadow on both slots
    clr(); seta(1, 10, 1, 2); step("R8");
    clr(); seta(3, 11, 1, 2); step("R8"); step("R8"); idle(3);
    clr(); seta(1, 10, 1, 2); step("R8");
    clr(); seta(0, 12, 1, 2); setb(3, 13, 3, 4); step("R8"); idle(3);
    clr(); seta(1, 0, 1, 2); step("R8");
    clr(); seta(3, 11, 1, 2); step("R8"); idle(3);

    // R9: bypass selects after alu producers in both pipes
    clr(); seta(0, 12, 1, 2); setb(0, 17, 3, 4); step("R9");
    clr(); seta(0, 13, 12, 17); setb(0, 18, 17, 12); step("R9"); idle(2);
    clr(); seta(3, 12, 1, 2); step("R9");
    clr(); seta(0, 13, 12, 1); repeat (3) step("R9"); idle(3);

    // R10: divide occupies its destination and the divider
    clr(); seta(4, 14, 1, 2); step("R10");
    clr(); seta(0, 20, 14, 3); repeat (3) step("R10");
    clr(); seta(4, 21, 1, 2); step("R10");
    clr(); s_done = 1; seta(0, 20, 14, 3); step("R10");
    clr(); seta(0, 20, 14, 3); step("R10");
    idle(2);

    // R11: downstream stall
    clr(); seta(0, 1, 2, 3); setb(0, 4, 5, 6); s_stall = 1; repeat (2) step("R11");
    idle(1);

    // random mix over a small register set
    for (int i = 0; i < 3000; i++) begin
      clr();
      s_av = ($urandom_range(0, 7) != 0); s_ac = $urandom_range(0, 5);
      s_ard = $urandom_range(0, 3); s_ar1 = $urandom_range(0, 3); s_ar2 = $urandom_range(0, 3);
      s_bv = ($urandom_range(0, 3) != 0); s_bc = $urandom_range(0, 5);
      s_brd = $urandom_range(0, 3); s_br1 = $urandom_range(0, 3); s_br2 = $urandom_range(0, 3);
      s_irq = ($urandom_range(0, 3) == 0);
      s_stall = ($urandom_range(0, 7) == 0);
      s_done = ($urandom_range(0, 3) == 0);
      step("R7");
    end

    summary();
  end
endmodule